// File: doc/BRIEF.md
# UART Interrupt Cause Aggregator

This block gathers the interrupt causes of a buffered serial port into one place. Four event pulses arrive from the receive, transmit and line logic: line status, received data available, character timeout and transmit space. The block also watches four asynchronous modem inputs, synchronises them and flags every change on them. Each cause is held in a sticky bit of a one-hot identification field, so several causes can be pending at once. Software reads one 32-bit status word and acknowledges causes by writing ones back into the low byte.

A single level interrupt output is the OR of all pending causes whose enable is set. Received data and character timeout share one enable. The modem-change delta bits are cleared together with the modem cause bit, so one acknowledge write retires both. If a cause fires in the same cycle as its acknowledge write, the new cause is kept.

Top module: `uirq_status_agg`

## Requirements
- R1: After reset the identification field (status bits 4:0), the modem delta bits (status bits 11:8) and `irq_out` are all zero.
- R2: A one-cycle pulse on `ev_line`, `ev_rxdata`, `ev_timeout` or `ev_txspace` sets status bit 0, 1, 2 or 3 at the next clock edge. The bit stays set until it is cleared, and any number of these bits may be set together.
- R3: `cfg_en` bit 0 enables bits 1 and 2 (received data and timeout). Bit 1 enables bit 3 (transmit space), bit 2 enables bit 0 (line status) and bit 3 enables bit 4 (modem status).
- R4: `irq_out` is high in every cycle in which at least one identification bit is set together with its enable, and low otherwise.
- R5: A write with `wr_valid` high, `wr_addr` equal to 0 and `wr_be[0]` high clears each identification bit whose matching bit in `wr_data[4:0]` is one, at the next edge. Zeros leave bits unchanged. A write to any other address, or with `wr_be[0]` low, changes nothing.
- R6: If a cause arrives in the same cycle as a write that clears it, the bit is set after that edge.
- R7: Status bits 15:12 show the synchronised levels of `modem_in[3:0]` (CTS, DSR, RI, DCD in that order), `SYNC_STAGES` edges after the input changes.
- R8: A change of a synchronised modem input sets its delta bit (status bits 8 to 11, same order) and status bit 4 one edge after the level appears. Clearing status bit 4 also clears all delta bits, unless a new change arrives in that cycle.
- R9: Status bits 23:16 carry `line_stat[7:0]` and bits 7:6 carry `rx_count_hi[1:0]`, neither touched by acknowledge writes. Bit 5 and bits 31:24 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_line | input | 1 | Line status event pulse |
| ev_rxdata | input | 1 | Received data available pulse |
| ev_timeout | input | 1 | Character timeout pulse |
| ev_txspace | input | 1 | Transmit space pulse |
| modem_in | input | 4 | Asynchronous modem inputs: CTS, DSR, RI, DCD |
| line_stat | input | 8 | Line status levels placed in the status word |
| rx_count_hi | input | 2 | Upper receive count bits placed in status bits 7:6 |
| cfg_en | input | 4 | Per-cause interrupt enables |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_be | input | 4 | Write byte enables |
| wr_data | input | 32 | Write data |
| status_word | output | 32 | Packed status word |
| irq_out | output | 1 | Level interrupt output |

## Verification
The bench goes after collisions between an event and the acknowledge of the same bit. A design where the clear wins would drop a cause and lose an interrupt. Partial acknowledges are checked to retire only the written bits, and writes with the wrong address or lane are checked to change nothing. A design that ignored the lane or address would lose pending causes on unrelated writes. Enable routing is probed one cause at a time, which catches a timeout routed to the wrong enable. Modem deltas are checked both to set on a change and to clear with the modem cause; a design that kept them would re-raise the modem cause forever.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ID_W = 5;
  localparam int MS_W = 4;
  localparam int EN_W = 4;

  typedef enum int {
    CAUSE_LINE    = 0,
    CAUSE_RXDATA  = 1,
    CAUSE_TIMEOUT = 2,
    CAUSE_TXSPACE = 3,
    CAUSE_MODEM   = 4
  } cause_e;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  function automatic logic [31:0] pack_status(
    input logic [ID_W-1:0] id,
    input logic [1:0]      rx_hi,
    input logic [MS_W-1:0] delta,
    input logic [MS_W-1:0] level,
    input logic [7:0]      lsr
  );
    logic [31:0] w;
    w        = '0;
    w[4:0]   = id;
    w[7:6]   = rx_hi;
    w[11:8]  = delta;
    w[15:12] = level;
    w[23:16] = lsr;
    return w;
  endfunction

  function automatic logic [ID_W-1:0] enable_mask(input logic [EN_W-1:0] en);
    logic [ID_W-1:0] m;
    m                = '0;
    m[CAUSE_LINE]    = en[EN_LINE];
    m[CAUSE_RXDATA]  = en[EN_RX];
    m[CAUSE_TIMEOUT] = en[EN_RX];
    m[CAUSE_TXSPACE] = en[EN_TX];
    m[CAUSE_MODEM]   = en[EN_MODEM];
    return m;
  endfunction
endpackage

// File: rtl/uirq_modem_sync.sv
module uirq_modem_sync #(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         clr_delta,
  output logic [W-1:0] level,
  output logic [W-1:0] delta,
  output logic         change
);
  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] prev_q;
  logic [W-1:0] delta_q, delta_d;
  logic [W-1:0] chg;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= '0;
          else        sync_q[0] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign level = sync_q[SYNC_STAGES-1];
  assign chg   = level ^ prev_q;

  always_comb begin
    delta_d = clr_delta ? '0 : delta_q;
    delta_d = delta_d | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= level;
      delta_q <= delta_d;
    end
  end

  assign delta  = delta_q;
  assign change = |chg;
endmodule

// File: rtl/uirq_cause_reg.sv
module uirq_cause_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] id_q
);
  logic [N-1:0] id_d;
  logic [N-1:0] id_en;

  genvar b;
  generate
    for (b = 0; b < N; b++) begin : g_bit
      always_comb begin
        id_en[b] = set[b] | clr[b];
        id_d[b]  = set[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        id_q[b] <= 1'b0;
        else if (id_en[b]) id_q[b] <= id_d[b];
      end
    end
  endgenerate
endmodule

// File: rtl/uirq_gate.sv
module uirq_gate
  import uirq_pkg::*;
(
  input  logic [ID_W-1:0] id,
  input  logic [EN_W-1:0] en,
  output logic            irq
);
  logic [ID_W-1:0] mask;
  always_comb begin
    mask = enable_mask(en);
    irq  = |(id & mask);
  end
endmodule

// File: rtl/uirq_status_agg.sv
module uirq_status_agg
  import uirq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_line,
  input  logic              ev_rxdata,
  input  logic              ev_timeout,
  input  logic              ev_txspace,
  input  logic [3:0]        modem_in,
  input  logic [7:0]        line_stat,
  input  logic [1:0]        rx_count_hi,
  input  logic [3:0]        cfg_en,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic [31:0]       status_word,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(STAT_OFFSET);

  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  logic            ack_hit;
  logic [ID_W-1:0] clr_bits;
  logic [ID_W-1:0] set_bits;
  logic [ID_W-1:0] id_q;
  logic [MS_W-1:0] ms_level, ms_delta;
  logic            ms_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    ack_hit  = wr_valid && (wr_addr == OFF) && wr_be[0];
    clr_bits = ack_hit ? wr_data[ID_W-1:0] : '0;
    set_bits                = '0;
    set_bits[CAUSE_LINE]    = ev_line;
    set_bits[CAUSE_RXDATA]  = ev_rxdata;
    set_bits[CAUSE_TIMEOUT] = ev_timeout;
    set_bits[CAUSE_TXSPACE] = ev_txspace;
    set_bits[CAUSE_MODEM]   = ms_change;
  end

  uirq_modem_sync #(.W(MS_W), .SYNC_STAGES(SYNC_STAGES)) u_ms (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pins      (modem_in),
    .clr_delta (clr_bits[CAUSE_MODEM]),
    .level     (ms_level),
    .delta     (ms_delta),
    .change    (ms_change)
  );

  uirq_cause_reg #(.N(ID_W)) u_cause (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (set_bits),
    .clr   (clr_bits),
    .id_q  (id_q)
  );

  uirq_gate u_gate (
    .id  (id_q),
    .en  (cfg_en),
    .irq (irq_out)
  );

  assign status_word = pack_status(id_q, rx_count_hi, ms_delta, ms_level, line_stat);
endmodule

// File: rtl/uirq_status_agg_chk.sv
module uirq_status_agg_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_rxdata,
  input logic              ev_txspace,
  input logic [3:0]        cfg_en,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        wr_be,
  input logic [31:0]       wr_data,
  input logic [31:0]       status_word,
  input logic              irq_out
);
  logic ack;
  assign ack = wr_valid && (wr_addr == '0) && wr_be[0];

  a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxdata |=> status_word[1]);

  a_r4_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[3] && cfg_en[1]) |-> irq_out);

  a_r4_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en == 4'b0000) |-> !irq_out);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wr_data[3] && !ev_txspace) |=> !status_word[3]);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wr_data[1] && ev_rxdata) |=> status_word[1]);

  a_r8_delta_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wr_data[4] && $stable(status_word[15:12])) |=> (status_word[11:8] == 4'b0000));
endmodule

bind uirq_status_agg uirq_status_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_rxdata   (ev_rxdata),
  .ev_txspace  (ev_txspace),
  .cfg_en      (cfg_en),
  .wr_valid    (wr_valid),
  .wr_addr     (wr_addr),
  .wr_be       (wr_be),
  .wr_data     (wr_data),
  .status_word (status_word),
  .irq_out     (irq_out)
);

// File: tb/sim_uirq_status_agg.sv
module sim_uirq_status_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_line, ev_rxdata, ev_timeout, ev_txspace;
  logic [3:0]  modem_in;
  logic [7:0]  line_stat;
  logic [1:0]  rx_count_hi;
  logic [3:0]  cfg_en;
  logic        wr_valid;
  logic [11:0] wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [31:0] status_word;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uirq_status_agg u0 (
    .clk(clk), .rst_n(rst_n), .ev_line(ev_line), .ev_rxdata(ev_rxdata),
    .ev_timeout(ev_timeout), .ev_txspace(ev_txspace), .modem_in(modem_in),
    .line_stat(line_stat), .rx_count_hi(rx_count_hi), .cfg_en(cfg_en),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .status_word(status_word), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [3:0] ev;
    logic [4:0] clr;
    logic [4:0] expect_id;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{4'b0001, 5'b00000, 5'b00001},
    '{4'b0010, 5'b00000, 5'b00011},
    '{4'b0100, 5'b00000, 5'b00111},
    '{4'b1000, 5'b00000, 5'b01111},
    '{4'b0000, 5'b00011, 5'b01100},
    '{4'b0000, 5'b01100, 5'b00000},
    '{4'b1010, 5'b00000, 5'b01010},
    '{4'b0010, 5'b00010, 5'b01010},
    '{4'b0000, 5'b11111, 5'b00000},
    '{4'b1111, 5'b00000, 5'b01111},
    '{4'b0000, 5'b00000, 5'b01111},
    '{4'b0000, 5'b01111, 5'b00000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] ev, input logic wv, input logic [11:0] a,
                      input logic [3:0] be, input logic [31:0] d);
    {ev_txspace, ev_timeout, ev_rxdata, ev_line} = ev;
    wr_valid = wv; wr_addr = a; wr_be = be; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    {ev_txspace, ev_timeout, ev_rxdata, ev_line} = 4'b0000;
    wr_valid = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
  endtask

  task automatic ack(input logic [4:0] bits);
    step(4'b0000, 1'b1, 12'h000, 4'b0001, {27'd0, bits});
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {ev_txspace, ev_timeout, ev_rxdata, ev_line} = 4'b0000;
    modem_in = 4'b0000; line_stat = 8'h00; rx_count_hi = 2'b00;
    cfg_en = 4'b1111;
    wr_valid = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 id", {27'd0, status_word[4:0]}, 32'h0);
    check("R1 delta", {28'd0, status_word[11:8]}, 32'h0);
    check("R1 irq", {31'd0, irq_out}, 32'h0);

    // R2 R5 R6 R4 table walk
    foreach (VEC[i]) begin
      step(VEC[i].ev, |VEC[i].clr, 12'h000, 4'b0001, {27'd0, VEC[i].clr});
      check($sformatf("R2/R5/R6 vec %0d id", i), {27'd0, status_word[4:0]},
            {27'd0, VEC[i].expect_id});
      check($sformatf("R4 vec %0d irq", i), {31'd0, irq_out}, {31'd0, |VEC[i].expect_id});
    end

    // R5 ignored writes: wrong address, lane 0 disabled
    step(4'b1111, 1'b0, 12'h000, 4'b0000, 32'h0);
    step(4'b0000, 1'b1, 12'h004, 4'b0001, 32'h1F);
    check("R5 wrong address", {27'd0, status_word[4:0]}, 32'h0F);
    step(4'b0000, 1'b1, 12'h000, 4'b1110, 32'h1F);
    check("R5 lane0 off", {27'd0, status_word[4:0]}, 32'h0F);
    ack(5'b11111);

    // R3 enable routing, R4
    cfg_en = 4'b0000;
    step(4'b0010, 1'b0, 12'h0, 4'h0, 32'h0);
    check("R3 rx no enable", {31'd0, irq_out}, 32'h0);
    cfg_en = 4'b0001; #1;
    check("R3 rx enable0", {31'd0, irq_out}, 32'h1);
    ack(5'b00010);
    step(4'b0100, 1'b0, 12'h0, 4'h0, 32'h0);
    check("R3 timeout enable0", {31'd0, irq_out}, 32'h1);
    cfg_en = 4'b0010; #1;
    check("R3 timeout not enable1", {31'd0, irq_out}, 32'h0);
    ack(5'b00100);
    step(4'b1000, 1'b0, 12'h0, 4'h0, 32'h0);
    check("R3 tx enable1", {31'd0, irq_out}, 32'h1);
    cfg_en = 4'b1101; #1;
    check("R3 tx not others", {31'd0, irq_out}, 32'h0);
    ack(5'b01000);
    cfg_en = 4'b0100;
    step(4'b0001, 1'b0, 12'h0, 4'h0, 32'h0);
    check("R3 line enable2", {31'd0, irq_out}, 32'h1);
    ack(5'b00001);
    check("R4 all clear", {31'd0, irq_out}, 32'h0);

    // R7 R8 modem change on CTS
    cfg_en = 4'b1000;
    modem_in = 4'b0001;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R7 level after sync", {28'd0, status_word[15:12]}, 32'h1);
    check("R8 delta not yet", {28'd0, status_word[11:8]}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 delta set", {28'd0, status_word[11:8]}, 32'h1);
    check("R8 modem id", {31'd0, status_word[4]}, 32'h1);
    check("R8 modem irq", {31'd0, irq_out}, 32'h1);
    ack(5'b10000);
    check("R8 delta cleared", {28'd0, status_word[11:8]}, 32'h0);
    check("R8 level kept", {28'd0, status_word[15:12]}, 32'h1);
    check("R8 id cleared", {31'd0, status_word[4]}, 32'h0);
    modem_in = 4'b1001;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check("R8 dcd delta", {28'd0, status_word[11:8]}, 32'h8);
    check("R7 dcd level", {28'd0, status_word[15:12]}, 32'h9);
    ack(5'b10000);

    // R9 pass-through and untouched fields
    line_stat = 8'hA5; rx_count_hi = 2'b11;
    step(4'b0000, 1'b1, 12'h000, 4'b0001, 32'hFFFF_FFFF);
    check("R9 word", status_word, 32'h00A5_90C0);
    line_stat = 8'h3C; rx_count_hi = 2'b01; #1;
    check("R9 follow", status_word & 32'hFFFF_00E0, 32'h003C_0040);

    finish_run();
  end
endmodule